// File: doc/BRIEF.md
# Oldest-Ready Egress Packet Arbiter

This block decides which waiting packet goes out on one egress port next. Each ingress port that has a packet at the head of its queue for this egress presents a candidate. A candidate carries an arrival timestamp, the number of credits it needs and a flag that marks it as held back by packet ordering. The arbiter keeps a count of the egress credit that is available. In every cycle it grants the ready candidate that arrived first.

A candidate is ready when it is valid, its ordering flag is clear, and its credit need is no larger than the current credit count. The grant is a one-hot pop strobe back to the ingress queues, together with an encoded index. The granted cost comes off the credit count at the next clock edge. Credit returned by the link partner is added at the same edge. There is one fixed policy, with no modes and no weights.

Timestamps come from a free-running counter that wraps. Age is therefore judged by the sign of the modular difference between two stamps, so candidates stay correctly ordered across a wrap. This holds as long as live stamps are less than half the counter range apart.

Top module: `egress_age_arbiter`

## Requirements
- R1: After reset the credit count equals INIT_CREDIT and no grant is asserted while no candidate is valid.
- R2: Among ready candidates, the one with the oldest timestamp is granted.
- R3: A candidate whose cost exceeds the credit count is not ready. A cost exactly equal to the credit count is ready.
- R4: A candidate with its ordering-blocked flag set is never granted.
- R5: Timestamp age is compared modulo 2^TS_W: stamp a is older than stamp b when bit TS_W-1 of (a - b) is 1. For example, 16'hFFF0 is older than 16'h0005.
- R6: When ready candidates carry equal timestamps, the lowest ingress index wins.
- R7: At most one grant is issued per cycle. grant_onehot has exactly bit grant_idx set when grant_valid is 1, and is zero otherwise.
- R8: At each clock edge the credit count becomes its old value, minus the granted cost if a grant was asserted, plus credit_return.
- R9: With no ready candidate there is no grant, and the credit count changes only by credit_return.
- R10: A non-ready older candidate does not prevent a younger ready candidate on another ingress from being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | N | Head packet present, one bit per ingress |
| cand_ts | input | N*TS_W | Arrival timestamps, ingress i at bits [i*TS_W +: TS_W] |
| cand_cost | input | N*COST_W | Credit needed, ingress i at bits [i*COST_W +: COST_W] |
| cand_blocked | input | N | Ordering rule currently forbids sending, one bit per ingress |
| credit_return | input | CRED_W | Credit returned by the link this cycle |
| grant_valid | output | 1 | A candidate is granted this cycle |
| grant_idx | output | $clog2(N) | Index of the granted ingress |
| grant_onehot | output | N | Pop strobe to the granted ingress |
| credit_avail | output | CRED_W | Current credit count |

## Verification
The assertions assume that returned credit never pushes the count past CRED_W bits. They also assume that live timestamps lie within half the counter range of one another, so that the modular comparison is meaningful. The stimulus keeps the credit count well below 2^CRED_W and uses small credit returns. All stamps it presents fall inside a narrow window, including the one case that straddles the wrap point. The bench drives candidates only between clock edges and reads the grant before the edge that consumes it.

// File: rtl/egress_age_arbiter.sv
module egress_age_arbiter #(
  parameter int N           = 4,
  parameter int TS_W        = 16,
  parameter int COST_W      = 8,
  parameter int CRED_W      = 10,
  parameter int INIT_CREDIT = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          cand_valid,
  input  logic [N*TS_W-1:0]     cand_ts,
  input  logic [N*COST_W-1:0]   cand_cost,
  input  logic [N-1:0]          cand_blocked,
  input  logic [CRED_W-1:0]     credit_return,
  output logic                  grant_valid,
  output logic [$clog2(N)-1:0]  grant_idx,
  output logic [N-1:0]          grant_onehot,
  output logic [CRED_W-1:0]     credit_avail
);

  localparam int IDX_W = $clog2(N);

  logic [CRED_W-1:0] credit_q;
  logic [N-1:0]      ready;
  logic              found;
  logic [IDX_W-1:0]  pick;
  logic [TS_W-1:0]   pick_ts;
  logic [TS_W-1:0]   diff;
  logic [COST_W-1:0] grant_cost;
  logic [CRED_W:0]   credit_next;

  always_comb begin
    ready   = '0;
    found   = 1'b0;
    pick    = '0;
    pick_ts = '0;
    diff    = '0;
    for (int i = 0; i < N; i++) begin
      ready[i] = cand_valid[i] && !cand_blocked[i] &&
                 ((CRED_W+1)'(cand_cost[i*COST_W +: COST_W]) <= (CRED_W+1)'(credit_q));
      diff = cand_ts[i*TS_W +: TS_W] - pick_ts;
      if (ready[i] && (!found || diff[TS_W-1])) begin
        found   = 1'b1;
        pick    = IDX_W'(i);
        pick_ts = cand_ts[i*TS_W +: TS_W];
      end
    end
  end

  assign grant_valid  = found;
  assign grant_idx    = pick;
  assign grant_onehot = found ? (N'(1) << pick) : '0;
  assign grant_cost   = found ? cand_cost[pick*COST_W +: COST_W] : '0;
  assign credit_next  = (CRED_W+1)'(credit_q) - (CRED_W+1)'(grant_cost)
                      + (CRED_W+1)'(credit_return);
  assign credit_avail = credit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) credit_q <= CRED_W'(INIT_CREDIT);
    else        credit_q <= credit_next[CRED_W-1:0];
  end

  assert_onehot_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (grant_onehot != '0)));

  assert_grant_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((CRED_W+1)'(cand_cost[grant_idx*COST_W +: COST_W]) <= (CRED_W+1)'(credit_avail)));

  assert_grant_unblocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (cand_valid[grant_idx] && !cand_blocked[grant_idx]));

  assert_idle_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && credit_return == '0) |=> $stable(credit_avail));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !credit_next[CRED_W]);

endmodule

// File: tb/test_egress_age_arbiter.sv
`timescale 1ns/1ps
module test_egress_age_arbiter;
  localparam int N = 4, TS_W = 16, COST_W = 8, CRED_W = 10;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] cand_valid = '0, cand_blocked = '0;
  logic [N*TS_W-1:0] cand_ts = '0;
  logic [N*COST_W-1:0] cand_cost = '0;
  logic [CRED_W-1:0] credit_return = '0;
  logic grant_valid;
  logic [1:0] grant_idx;
  logic [N-1:0] grant_onehot;
  logic [CRED_W-1:0] credit_avail;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  egress_age_arbiter #(.N(N), .TS_W(TS_W), .COST_W(COST_W), .CRED_W(CRED_W), .INIT_CREDIT(64))
    i_egress_age_arbiter (.clk, .rst_n, .cand_valid, .cand_ts, .cand_cost, .cand_blocked,
      .credit_return, .grant_valid, .grant_idx, .grant_onehot, .credit_avail);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cand(int i, logic v, int ts, int cost, logic blk);
    cand_valid[i] = v;
    cand_ts[i*TS_W +: TS_W] = TS_W'(ts);
    cand_cost[i*COST_W +: COST_W] = COST_W'(cost);
    cand_blocked[i] = blk;
  endtask

  task automatic clear();
    cand_valid = '0; cand_blocked = '0; cand_ts = '0; cand_cost = '0; credit_return = '0;
  endtask

  // called at a negedge with candidates driven; checks grant, then credit after the edge
  task automatic expect_cycle(string req, int gv, int gi, int cred_after);
    #1;
    chk(req, grant_valid, gv);
    if (gv != 0) begin
      chk({req, " idx"}, grant_idx, gi);
      chk({"R7 onehot"}, grant_onehot, 1 << gi);
    end else chk("R7 onehot idle", grant_onehot, 0);
    @(posedge clk); #1;
    chk({"R8 credit ", req}, credit_avail, cred_after);
    clear();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 credit", credit_avail, 64);
    chk("R1 grant", grant_valid, 0);
  endtask

  task automatic t_oldest(); // R2
    cand(0, 1, 100, 1, 0); cand(1, 1, 50, 1, 0); cand(2, 1, 200, 1, 0); cand(3, 1, 75, 1, 0);
    expect_cycle("R2", 1, 1, 63);
  endtask

  task automatic t_credit_skip(); // R3 R10
    cand(0, 1, 10, 100, 0); cand(1, 1, 20, 5, 0);
    expect_cycle("R3 R10", 1, 1, 58);
  endtask

  task automatic t_exact(); // R3 boundary
    cand(2, 1, 5, 58, 0);
    expect_cycle("R3 exact", 1, 2, 0);
  endtask

  task automatic t_none(); // R9
    cand(0, 1, 3, 1, 0); cand(1, 1, 4, 2, 0);
    expect_cycle("R9 no credit", 0, 0, 0);
  endtask

  task automatic t_return(); // R8
    credit_return = 40;
    expect_cycle("R8 return", 0, 0, 40);
  endtask

  task automatic t_blocked(); // R4 R10
    cand(0, 1, 1, 2, 1); cand(3, 1, 9, 2, 0);
    expect_cycle("R4", 1, 3, 38);
  endtask

  task automatic t_all_blocked(); // R4 R9
    cand(0, 1, 1, 1, 1); cand(2, 1, 2, 1, 1);
    expect_cycle("R4 R9 all blocked", 0, 0, 38);
  endtask

  task automatic t_wrap(); // R5
    cand(0, 1, 16'h0005, 1, 0); cand(1, 1, 16'hFFF0, 1, 0);
    expect_cycle("R5 wrap", 1, 1, 37);
  endtask

  task automatic t_tie(); // R6
    cand(3, 1, 300, 1, 0); cand(2, 1, 300, 1, 0);
    expect_cycle("R6 tie", 1, 2, 36);
  endtask

  task automatic t_grant_and_return(); // R8
    cand(0, 1, 7, 6, 0); credit_return = 10;
    expect_cycle("R8 both", 1, 0, 40);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_oldest();
    t_credit_skip();
    t_exact();
    t_none();
    t_return();
    t_blocked();
    t_all_blocked();
    t_wrap();
    t_tie();
    t_grant_and_return();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule